// File: doc/BRIEF.md
# Averaging CIC Decimator for Gain-Control Updates

This block turns a fast stream of unsigned power samples into slow update samples for a gain-control loop. Incoming samples are first grouped and averaged over one to four consecutive values. Each average then enters a first-order integrate-and-dump (CIC) decimator. Every `ratio` averages, it emits the sum of those averages, shifted right by a programmable amount.

The averaging count, the shift and the ratio sit in shadow registers. These registers change only when an update request arrives together with the init qualifier. An update request always forces an immediate output of whatever has been gathered since the last output, and it restarts the decimation count. With init, the request also clears the decimator state and the partial average and loads new settings from the configuration word.

Top module: `agc_avg_cic`

## Requirements
- R1: After reset `out_valid` is low. The shadow settings are averaging code 0 (one sample), shift 0 and ratio code 0 (4096).
- R2: The averaging code in `cfg_word[1:0]` selects how many samples are averaged: code 0 means 1 sample, 1 means 2, 2 means 3 and 3 means 4. Codes 0, 1 and 3 give floor(sum/n).
- R3: With averaging code 2 (three samples), the average is floor(sum*21845/65536).
- R4: The ratio field `cfg_word[17:6]` holding N in 1..4095 makes one output per N averages. Field value 0 means 4096.
- R5: Each output equals the sum of the averages since the previous output, shifted right by the scale field `cfg_word[5:2]` (0..15). The output is `IN_W+RATIO_W` bits wide.
- R6: A request with init emits an output computed with the old settings. It then clears the decimator and the partial average, loads all three fields from `cfg_word`, and drops any sample offered in that cycle.
- R7: A request without init emits the sum gathered since the last output and restarts the decimation count. The settings and the partial average are kept. A request with nothing gathered emits 0.
- R8: Changing `cfg_word`, or raising `upd_init` without `upd_req`, has no effect on later outputs.
- R9: `out_valid` is a one-cycle pulse per output. A natural output appears 2 cycles after the clock edge that accepts its last sample. A forced output appears 1 cycle after the request edge.
- R10: The integrator wraps modulo 2^(IN_W+RATIO_W), and outputs stay exact after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Power sample strobe |
| in_sample | input | IN_W | Unsigned power sample |
| cfg_word | input | RATIO_W+6 | Averaging code [1:0], scale [5:2], ratio [RATIO_W+5:6] |
| upd_req | input | 1 | Force an update output and restart decimation |
| upd_init | input | 1 | Qualifies `upd_req` as an init request |
| out_valid | output | 1 | Update sample strobe |
| out_sample | output | IN_W+RATIO_W | Decimated, shifted update sample |

## Verification
A sample that completes a decimation period is due 2 cycles after its accepting edge: one cycle in the averager register and one in the output register. A forced update is due 1 cycle after its request edge. The driver tasks compute each expected value and its due cycle from a free-running cycle count, then queue them. The monitor samples on the falling edge and compares both the value and the arrival cycle, so an early, late, missing or extra pulse is caught. Requests are preceded by two idle cycles, so no natural output coincides with a forced one.

// File: rtl/agc_avg_cic_pkg.sv
package agc_avg_cic_pkg;
   localparam int AVG_F_W   = 2;
   localparam int SCALE_F_W = 4;
   localparam int SCALE_LSB = 2;
   localparam int RATIO_LSB = 6;
   localparam int RECIP3    = 21845;
   localparam int RECIP3_SH = 16;

   typedef enum logic [1:0] {
      AVG_N1 = 2'd0,
      AVG_N2 = 2'd1,
      AVG_N3 = 2'd2,
      AVG_N4 = 2'd3
   } avg_sel_e;
endpackage

// File: rtl/agc_avg_stage.sv
module agc_avg_stage
   import agc_avg_cic_pkg::*;
#(
   parameter int IN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  avg_sel_e        sel,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_sample,
   output logic            avg_valid,
   output logic [IN_W-1:0] avg_data
);
   localparam int SUM_W  = IN_W + AVG_F_W;
   localparam int PROD_W = SUM_W + RECIP3_SH;

   logic [AVG_F_W-1:0] cnt_q;
   logic [SUM_W-1:0]   sum_q, sum_nx;
   logic [PROD_W-1:0]  prod;
   logic [IN_W-1:0]    quot;
   logic               last;

   always_comb begin
      sum_nx = sum_q + SUM_W'(in_sample);
      last   = (cnt_q == AVG_F_W'(sel));
      prod   = PROD_W'(sum_nx) * PROD_W'(RECIP3);
      case (sel)
         AVG_N1:  quot = IN_W'(sum_nx);
         AVG_N2:  quot = IN_W'(sum_nx >> 1);
         AVG_N3:  quot = IN_W'(prod >> RECIP3_SH);
         default: quot = IN_W'(sum_nx >> 2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         sum_q     <= '0;
         avg_valid <= 1'b0;
         avg_data  <= '0;
      end else if (clr) begin
         cnt_q     <= '0;
         sum_q     <= '0;
         avg_valid <= 1'b0;
      end else begin
         avg_valid <= 1'b0;
         if (in_valid) begin
            if (last) begin
               cnt_q     <= '0;
               sum_q     <= '0;
               avg_valid <= 1'b1;
               avg_data  <= quot;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               sum_q <= sum_nx;
            end
         end
      end
   end
endmodule

// File: rtl/agc_cic_dec.sv
module agc_cic_dec
   import agc_avg_cic_pkg::*;
#(
   parameter int IN_W    = 16,
   parameter int RATIO_W = 12,
   localparam int ACC_W  = IN_W + RATIO_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 avg_valid,
   input  logic [IN_W-1:0]      avg_data,
   input  logic [RATIO_W-1:0]   ratio_m1,
   input  logic [SCALE_F_W-1:0] scale,
   input  logic                 req,
   input  logic                 init,
   output logic                 out_valid,
   output logic [ACC_W-1:0]     out_sample
);
   logic [ACC_W-1:0]   integ_q, integ_nx, comb_q, diff;
   logic [RATIO_W-1:0] dcnt_q;
   logic               natural, fire;

   always_comb begin
      integ_nx = integ_q + (avg_valid ? ACC_W'(avg_data) : '0);
      diff     = integ_nx - comb_q;
      natural  = avg_valid && (dcnt_q == ratio_m1);
      fire     = natural || req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ_q    <= '0;
         comb_q     <= '0;
         dcnt_q     <= '0;
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_sample <= diff >> scale;
            comb_q     <= integ_nx;
         end
         if (req && init) begin
            integ_q <= '0;
            comb_q  <= '0;
            dcnt_q  <= '0;
         end else begin
            integ_q <= integ_nx;
            if (req)
               dcnt_q <= '0;
            else if (avg_valid)
               dcnt_q <= natural ? '0 : dcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/agc_avg_cic.sv
module agc_avg_cic
   import agc_avg_cic_pkg::*;
#(
   parameter int IN_W    = 16,
   parameter int RATIO_W = 12,
   localparam int ACC_W  = IN_W + RATIO_W,
   localparam int CFG_W  = RATIO_LSB + RATIO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_sample,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             upd_req,
   input  logic             upd_init,
   output logic             out_valid,
   output logic [ACC_W-1:0] out_sample
);
   if (IN_W < 1 || IN_W > 32) begin : g_bad_in_w
      $error("agc_avg_cic: IN_W out of range");
   end
   if (RATIO_W < 1 || RATIO_W > 16) begin : g_bad_ratio_w
      $error("agc_avg_cic: RATIO_W out of range");
   end

   avg_sel_e               sh_avg;
   logic [SCALE_F_W-1:0]   sh_scale;
   logic [RATIO_W-1:0]     sh_ratio;
   logic [RATIO_W-1:0]     ratio_m1;
   logic                   load;
   logic                   avg_v;
   logic [IN_W-1:0]        avg_d;

   assign load     = upd_req && upd_init;
   assign ratio_m1 = sh_ratio - RATIO_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_avg   <= AVG_N1;
         sh_scale <= '0;
         sh_ratio <= '0;
      end else if (load) begin
         sh_avg   <= avg_sel_e'(cfg_word[AVG_F_W-1:0]);
         sh_scale <= cfg_word[SCALE_LSB +: SCALE_F_W];
         sh_ratio <= cfg_word[RATIO_LSB +: RATIO_W];
      end
   end

   agc_avg_stage #(.IN_W(IN_W)) i_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (load),
      .sel       (sh_avg),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .avg_valid (avg_v),
      .avg_data  (avg_d)
   );

   agc_cic_dec #(.IN_W(IN_W), .RATIO_W(RATIO_W)) i_cic (
      .clk        (clk),
      .rst_n      (rst_n),
      .avg_valid  (avg_v),
      .avg_data   (avg_d),
      .ratio_m1   (ratio_m1),
      .scale      (sh_scale),
      .req        (upd_req),
      .init       (upd_init),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );
endmodule

// File: rtl/agc_avg_cic_chk.sv
module agc_avg_cic_chk #(
   parameter int IN_W    = 16,
   parameter int RATIO_W = 12,
   localparam int CFG_W  = 6 + RATIO_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               upd_req,
   input logic               upd_init,
   input logic [CFG_W-1:0]   cfg_word,
   input logic               out_valid,
   input logic               avg_v,
   input logic [1:0]         sh_avg,
   input logic [3:0]         sh_scale,
   input logic [RATIO_W-1:0] sh_ratio
);
   assert_req_emits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req |=> out_valid);

   assert_out_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(upd_req) || $past(avg_v)));

   assert_avg_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      avg_v |-> ($past(in_valid) && !$past(upd_req && upd_init)));

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_req && upd_init) |=> $stable({sh_avg, sh_scale, sh_ratio}));

   assert_shadow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_req && upd_init) |=> ({sh_avg, sh_scale, sh_ratio} ==
         $past({cfg_word[1:0], cfg_word[5:2], cfg_word[CFG_W-1:6]})));

   assert_init_drops_avg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_req && upd_init) |=> !avg_v);
endmodule

bind agc_avg_cic agc_avg_cic_chk #(.IN_W(IN_W), .RATIO_W(RATIO_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .upd_req   (upd_req),
   .upd_init  (upd_init),
   .cfg_word  (cfg_word),
   .out_valid (out_valid),
   .avg_v     (avg_v),
   .sh_avg    (sh_avg),
   .sh_scale  (sh_scale),
   .sh_ratio  (sh_ratio)
);

// File: tb/test_agc_avg_cic.sv
module test_agc_avg_cic;
   localparam int IN_W    = 16;
   localparam int RATIO_W = 12;
   localparam int ACC_W   = IN_W + RATIO_W;
   localparam longint ACC_MASK = (64'd1 << ACC_W) - 1;

   typedef struct {
      longint val;
      int     due;
      string  tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [IN_W-1:0]    in_sample = '0;
   logic [RATIO_W+5:0] cfg_word = '0;
   logic               upd_req = 1'b0;
   logic               upd_init = 1'b0;
   logic               out_valid;
   logic [ACC_W-1:0]   out_sample;

   int     checks = 0;
   int     fails = 0;
   int     cyc = 0;
   bit     done = 1'b0;
   exp_t   sb[$];

   int     m_avg = 0, m_scale = 0, m_ratio = 4096;
   longint pa_sum = 0, d_sum = 0;
   int     pa_cnt = 0, d_cnt = 0;

   agc_avg_cic #(.IN_W(IN_W), .RATIO_W(RATIO_W)) i_agc_avg_cic (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .cfg_word(cfg_word), .upd_req(upd_req), .upd_init(upd_init),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [RATIO_W+5:0] mk_cfg(input int avg, input int scale, input int ratio);
      return {RATIO_W'(ratio), 4'(scale), 2'(avg)};
   endfunction

   function automatic longint avg_of(input longint s);
      case (m_avg)
         0:       return s;
         1:       return s >> 1;
         2:       return (s * 21845) >> 16;
         default: return s >> 2;
      endcase
   endfunction

   task automatic push(input longint v, input int due, input string tag);
      exp_t e;
      e.val = (v >> m_scale) & ACC_MASK;
      e.due = due;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic feed(input int v, input string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = IN_W'(v);
      pa_sum += v;
      if (pa_cnt == m_avg) begin
         d_sum += avg_of(pa_sum);
         pa_sum = 0;
         pa_cnt = 0;
         d_cnt++;
         if (d_cnt == m_ratio) begin
            push(d_sum, cyc + 2, tag);
            d_sum = 0;
            d_cnt = 0;
         end
      end else begin
         pa_cnt++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic request(input bit init, input logic [RATIO_W+5:0] cfg, input string tag);
      idle(2);
      @(negedge clk);
      cfg_word = cfg;
      upd_req  = 1'b1;
      upd_init = init;
      push(d_sum, cyc + 1, tag);
      d_sum = 0;
      d_cnt = 0;
      if (init) begin
         m_avg   = int'(cfg[1:0]);
         m_scale = int'(cfg[5:2]);
         m_ratio = (cfg[RATIO_W+5:6] == 0) ? 4096 : int'(cfg[RATIO_W+5:6]);
         pa_sum  = 0;
         pa_cnt  = 0;
      end
      @(negedge clk);
      upd_req  = 1'b0;
      upd_init = 1'b0;
   endtask

   // monitor: compares value and arrival cycle (R9)
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected output", longint'(out_sample), -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(longint'(out_sample) == e.val, e.tag, longint'(out_sample), e.val);
            check(cyc == e.due, {e.tag, " R9 timing"}, cyc, e.due);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

      // R1 defaults: one-sample average, ratio 4096, no natural output yet
      for (int i = 0; i < 10; i++) feed(100 + i, "R1 default");
      request(1'b0, mk_cfg(1, 1, 3), "R7 forced update of defaults");
      // config changed without init: still default settings (R8)
      for (int i = 0; i < 6; i++) feed(7 * i, "R8 cfg ignored");
      request(1'b0, mk_cfg(1, 1, 3), "R7 forced partial");

      // two-sample average, scale 1, ratio 3
      request(1'b1, mk_cfg(1, 1, 3), "R6 init emit");
      for (int i = 0; i < 12; i++) feed(1000 + 37 * i, "R2 R4 R5 avg2 ratio3");
      // three-sample average, ratio 2
      request(1'b1, mk_cfg(2, 0, 2), "R6 init emit");
      for (int i = 0; i < 12; i++) feed(65535 - 911 * i, "R3 avg3");
      // four-sample average, scale 2, ratio 1
      request(1'b1, mk_cfg(3, 2, 1), "R6 init emit");
      for (int i = 0; i < 8; i++) feed(3 * i + 5, "R2 avg4 scale2");

      // R8: cfg change and lone init have no effect
      idle(1);
      cfg_word = mk_cfg(0, 0, 5);
      for (int i = 0; i < 4; i++) feed(40 + i, "R8 cfg change");
      @(negedge clk);
      in_valid = 1'b0;
      upd_init = 1'b1;
      @(negedge clk);
      upd_init = 1'b0;
      for (int i = 0; i < 4; i++) feed(80 + i, "R8 lone init");

      // R7: request keeps the partial average
      for (int i = 0; i < 2; i++) feed(500, "R7 partial");
      request(1'b0, mk_cfg(0, 0, 5), "R7 empty update");
      for (int i = 0; i < 2; i++) feed(700, "R7 partial kept");

      // R6: init drops partial; ratio field 0 means 4096 (R4)
      for (int i = 0; i < 2; i++) feed(900, "R6 partial");
      request(1'b1, mk_cfg(0, 0, 0), "R6 init emit");
      for (int i = 0; i < 4096; i++) feed(i % 251, "R4 ratio 4096");

      // R7: early request restarts the count
      request(1'b1, mk_cfg(0, 0, 5), "R6 init emit");
      for (int i = 0; i < 3; i++) feed(11 * i + 2, "R7 early");
      request(1'b0, mk_cfg(0, 0, 5), "R7 early update");
      for (int i = 0; i < 5; i++) feed(300 + i, "R7 restart count");

      // R5: maximum shift
      request(1'b1, mk_cfg(0, 15, 4), "R6 init emit");
      for (int i = 0; i < 4; i++) feed(65535, "R5 scale 15");

      // R10: integrator wraps, outputs stay exact
      request(1'b1, mk_cfg(0, 0, 1), "R6 init emit");
      for (int i = 0; i < 4200; i++) feed(65535, "R10 wrap");

      idle(6);
      check(sb.size() == 0, "R9 all outputs seen", sb.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule